// File: doc/BRIEF.md
# Segment Fault Suspicion Ranker

This block is the ranking stage that follows a comparator array watching a DC bus split into segments. Each sample tick it takes one set of per-segment threshold flags and deviation amplitudes. An insulation alarm starts a scan of fixed length. During the scan the block notes when each segment first goes over threshold and the largest deviation each one shows while flagged. It also checks every far segment against the near reference segment, which is segment 0 and lies next to the grounding point, using a fixed-point ratio. Each far segment that breaks the ratio earns points.

When the window closes, the segment that both went over threshold first and showed the largest deviation gets the biggest bonus. The block then ranks all segments and reports the top segment, its score, and the timestamps that open and close the measurement window. It then drops back to idle and waits for the next alarm.

Samples come in on a valid/ready stream. The block stalls the stream only in the two cycles that close a scan. A source that sees `s_ready` low must hold its sample until it is taken. Samples offered while idle are accepted and thrown away. The result comes out as a one-cycle pulse and has no back-pressure.

Top module: `fault_rank_engine`

## Requirements
- R1: When `alarm_i` is high in idle, a scan starts. `now_ts_i` of that cycle becomes the window start time, and samples offered while idle have no effect on any result.
- R2: A scan ends after WIN_TICKS (default 40) accepted samples. `res_valid` is high for exactly one cycle, two cycles after the last sample is accepted. `res_t_end` equals `now_ts_i` of the cycle in which the last sample was accepted.
- R3: On every accepted sample, each far segment i ≥ 1 whose amplitude × 4 is strictly greater than the segment-0 amplitude × RATIO_Q (default 8, so a factor of 2.0 in quarter steps) gains RATIO_PTS (default 2). Equality gives no credit.
- R4: Each segment records the tick index (0-based, counted in accepted samples) of its first flagged sample. The earliest segment is the one with the smallest index, and a tie goes to the lower segment number.
- R5: The largest segment is the crossed segment with the highest amplitude seen on its flagged samples, and a tie goes to the lower segment number. If the earliest and largest segments are the same, it gains LEAD_BONUS (16). Otherwise each of the two gains SIDE_BONUS (4). If nothing crossed, no bonus is given.
- R6: Scores are cleared at scan start and saturate at 2^SCORE_W−1 (63). They never wrap.
- R7: The reported segment has the highest score. A tie goes to the segment with the earlier first crossing, where a segment that never crossed counts as latest. A remaining tie goes to the lower segment number.
- R8: `s_ready` is low in the two cycles between the last accepted sample and the result pulse, and high at all other times.
- R9: After reset, `res_valid` is 0, `s_ready` is 1 and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alarm_i | input | 1 | Global insulation alarm; starts a scan when idle |
| now_ts_i | input | TS_W | Current time-base value |
| s_valid | input | 1 | Sample set valid |
| s_ready | output | 1 | Sample set accepted this cycle when valid |
| s_flag | input | NSEG | Per-segment threshold-crossed flags |
| s_amp | input | NSEG*AMP_W | Per-segment deviation amplitudes, segment i at bits i*AMP_W upward |
| res_valid | output | 1 | One-cycle result strobe |
| res_seg | output | IDX_W | Top-ranked segment number |
| res_score | output | SCORE_W | Score of the top-ranked segment |
| res_t_start | output | TS_W | Window start timestamp |
| res_t_end | output | TS_W | Window end timestamp |

## Verification
Directed scans separate the ranking cases from one another:
- one segment that is both first and largest (full bonus);
- first and largest on different segments, giving a score tie that crossing time must settle;
- simultaneous crossings that fall through to segment order;
- scores made only from ratio hits with no crossings.

A ratio scan puts the far amplitude exactly at the factor and one step above it, which shows whether the comparison is strict. A long run of ratio hits shows saturation as opposed to wrap-around. An all-quiet scan run after idle traffic shows that idle samples are dropped. Seeded random scans with gaps in `s_valid` exercise the window count and the end timestamp against a model in the bench.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_BONUS = 2'd2,
    ST_RANK  = 2'd3
  } fr_state_t;
endpackage

// File: rtl/fr_track.sv
// Per-segment first-crossing tick and flagged peak amplitude.
module fr_track #(
  parameter int NSEG   = 4,
  parameter int AMP_W  = 12,
  parameter int TICK_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          en_i,
  input  logic [TICK_W-1:0]             tick_i,
  input  logic [NSEG-1:0]               flag_i,
  input  logic [NSEG-1:0][AMP_W-1:0]    amp_i,
  output logic [NSEG-1:0]               crossed_o,
  output logic [NSEG-1:0][TICK_W-1:0]   cross_tick_o,
  output logic [NSEG-1:0][AMP_W-1:0]    peak_o
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        crossed_o[i]    <= 1'b0;
        cross_tick_o[i] <= '1;
        peak_o[i]       <= '0;
      end else if (clr_i) begin
        crossed_o[i]    <= 1'b0;
        cross_tick_o[i] <= '1;
        peak_o[i]       <= '0;
      end else if (en_i && flag_i[i]) begin
        if (!crossed_o[i]) begin
          crossed_o[i]    <= 1'b1;
          cross_tick_o[i] <= tick_i;
        end
        if (amp_i[i] > peak_o[i]) peak_o[i] <= amp_i[i];
      end
    end

    // R4: once a first crossing is recorded it stays until the next scan
    a_r4_first_cross_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && crossed_o[i]) |=> (crossed_o[i] && $stable(cross_tick_o[i])));

    // R5: the flagged peak only grows within a scan
    a_r5_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (peak_o[i] >= $past(peak_o[i])));
  end
endmodule

// File: rtl/fr_lead.sv
// Picks the earliest-crossing and the largest-peak segment.
module fr_lead #(
  parameter int NSEG   = 4,
  parameter int AMP_W  = 12,
  parameter int TICK_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic [NSEG-1:0]             crossed_i,
  input  logic [NSEG-1:0][TICK_W-1:0] cross_tick_i,
  input  logic [NSEG-1:0][AMP_W-1:0]  peak_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            early_o,
  output logic [IDX_W-1:0]            large_o
);
  logic [TICK_W-1:0] best_t;
  logic [AMP_W-1:0]  best_a;

  always_comb begin
    any_o   = 1'b0;
    early_o = '0;
    large_o = '0;
    best_t  = '1;
    best_a  = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (crossed_i[i]) begin
        if (!any_o || cross_tick_i[i] < best_t) begin
          early_o = IDX_W'(i);
          best_t  = cross_tick_i[i];
        end
        if (!any_o || peak_i[i] > best_a) begin
          large_o = IDX_W'(i);
          best_a  = peak_i[i];
        end
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fr_score.sv
// Saturating score per segment: ratio credits during scan, bonus at close.
module fr_score #(
  parameter int NSEG       = 4,
  parameter int AMP_W      = 12,
  parameter int SCORE_W    = 6,
  parameter int IDX_W      = 2,
  parameter int RATIO_Q    = 8,
  parameter int RATIO_PTS  = 2,
  parameter int LEAD_BONUS = 16,
  parameter int SIDE_BONUS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          en_i,
  input  logic [NSEG-1:0][AMP_W-1:0]    amp_i,
  input  logic                          bonus_en_i,
  input  logic                          any_i,
  input  logic [IDX_W-1:0]              early_i,
  input  logic [IDX_W-1:0]              large_i,
  output logic [NSEG-1:0][SCORE_W-1:0]  score_o
);
  localparam int CMP_W = AMP_W + 10;
  localparam int SUM_W = SCORE_W + 8;
  localparam logic [SUM_W-1:0] SMAX = SUM_W'((1 << SCORE_W) - 1);

  logic [CMP_W-1:0] near_s;
  assign near_s = CMP_W'(amp_i[0]) * CMP_W'(RATIO_Q);

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic             hit;
    logic [SUM_W-1:0] add;
    logic [SUM_W-1:0] sum;

    if (i == 0) begin : g_near
      assign hit = 1'b0;
    end else begin : g_far
      logic [CMP_W-1:0] far_s;
      assign far_s = CMP_W'(amp_i[i]) << 2;
      assign hit   = far_s > near_s;
    end

    always_comb begin
      add = '0;
      if (en_i && hit) begin
        add = SUM_W'(RATIO_PTS);
      end else if (bonus_en_i && any_i) begin
        if (early_i == IDX_W'(i) && large_i == IDX_W'(i)) add = SUM_W'(LEAD_BONUS);
        else if (early_i == IDX_W'(i) || large_i == IDX_W'(i)) add = SUM_W'(SIDE_BONUS);
      end
      sum = SUM_W'(score_o[i]) + add;
      if (sum > SMAX) sum = SMAX;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     score_o[i] <= '0;
      else if (clr_i) score_o[i] <= '0;
      else            score_o[i] <= SCORE_W'(sum);
    end

    // R6: a full score never wraps
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && SUM_W'(score_o[i]) == SMAX) |=> (SUM_W'(score_o[i]) == SMAX));

    // R6: within a scan a score never falls
    a_r6_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (score_o[i] >= $past(score_o[i])));

    // R3: an unsaturated ratio hit adds exactly the ratio credit
    a_r3_ratio_credit: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && en_i && hit && (SUM_W'(score_o[i]) + SUM_W'(RATIO_PTS) <= SMAX))
      |=> (SUM_W'(score_o[i]) == SUM_W'($past(score_o[i])) + SUM_W'(RATIO_PTS)));
  end
endmodule

// File: rtl/fr_select.sv
// Final ranking: score, then earlier crossing, then lower index.
module fr_select #(
  parameter int NSEG    = 4,
  parameter int SCORE_W = 6,
  parameter int TICK_W  = 6,
  parameter int IDX_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NSEG-1:0][SCORE_W-1:0]  score_i,
  input  logic [NSEG-1:0][TICK_W-1:0]   cross_tick_i,
  output logic [IDX_W-1:0]              best_idx_o,
  output logic [SCORE_W-1:0]            best_score_o
);
  logic [TICK_W-1:0] best_t;

  always_comb begin
    best_idx_o   = '0;
    best_score_o = score_i[0];
    best_t       = cross_tick_i[0];
    for (int i = 1; i < NSEG; i++) begin
      if (score_i[i] > best_score_o ||
          (score_i[i] == best_score_o && cross_tick_i[i] < best_t)) begin
        best_idx_o   = IDX_W'(i);
        best_score_o = score_i[i];
        best_t       = cross_tick_i[i];
      end
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_chk
    // R7: no segment outscores the chosen one
    a_r7_winner_max: assert property (@(posedge clk) disable iff (!rst_n)
      score_i[i] <= best_score_o);
  end
endmodule

// File: rtl/fault_rank_engine.sv
module fault_rank_engine
  import fr_pkg::*;
#(
  parameter int NSEG       = 4,
  parameter int AMP_W      = 12,
  parameter int SCORE_W    = 6,
  parameter int TS_W       = 16,
  parameter int WIN_TICKS  = 40,
  parameter int RATIO_Q    = 8,
  parameter int RATIO_PTS  = 2,
  parameter int LEAD_BONUS = 16,
  parameter int SIDE_BONUS = 4,
  localparam int IDX_W     = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int TICK_W    = $clog2(WIN_TICKS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alarm_i,
  input  logic [TS_W-1:0]         now_ts_i,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [NSEG-1:0]         s_flag,
  input  logic [NSEG*AMP_W-1:0]   s_amp,
  output logic                    res_valid,
  output logic [IDX_W-1:0]        res_seg,
  output logic [SCORE_W-1:0]      res_score,
  output logic [TS_W-1:0]         res_t_start,
  output logic [TS_W-1:0]         res_t_end
);
  fr_state_t state_q;
  logic [TICK_W-1:0] tick_q;
  logic [TS_W-1:0]   start_q, end_q;
  logic clr, accept, bonus_en;

  logic [NSEG-1:0][AMP_W-1:0]   amp;
  logic [NSEG-1:0]              crossed;
  logic [NSEG-1:0][TICK_W-1:0]  cross_tick;
  logic [NSEG-1:0][AMP_W-1:0]   peak;
  logic [NSEG-1:0][SCORE_W-1:0] score;
  logic                         any_cross;
  logic [IDX_W-1:0]             early_idx, large_idx, best_idx;
  logic [SCORE_W-1:0]           best_score;

  assign amp      = s_amp;
  assign s_ready  = (state_q == ST_IDLE) || (state_q == ST_SCAN);
  assign clr      = (state_q == ST_IDLE) && alarm_i;
  assign accept   = (state_q == ST_SCAN) && s_valid;
  assign bonus_en = (state_q == ST_BONUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tick_q      <= '0;
      start_q     <= '0;
      end_q       <= '0;
      res_valid   <= 1'b0;
      res_seg     <= '0;
      res_score   <= '0;
      res_t_start <= '0;
      res_t_end   <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (alarm_i) begin
          start_q <= now_ts_i;
          tick_q  <= '0;
          state_q <= ST_SCAN;
        end
        ST_SCAN: if (accept) begin
          tick_q <= tick_q + 1'b1;
          if (tick_q == TICK_W'(WIN_TICKS - 1)) begin
            end_q   <= now_ts_i;
            state_q <= ST_BONUS;
          end
        end
        ST_BONUS: state_q <= ST_RANK;
        ST_RANK: begin
          res_valid   <= 1'b1;
          res_seg     <= best_idx;
          res_score   <= best_score;
          res_t_start <= start_q;
          res_t_end   <= end_q;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fr_track #(.NSEG(NSEG), .AMP_W(AMP_W), .TICK_W(TICK_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(accept), .tick_i(tick_q),
    .flag_i(s_flag), .amp_i(amp), .crossed_o(crossed),
    .cross_tick_o(cross_tick), .peak_o(peak)
  );

  fr_lead #(.NSEG(NSEG), .AMP_W(AMP_W), .TICK_W(TICK_W), .IDX_W(IDX_W)) u_lead (
    .crossed_i(crossed), .cross_tick_i(cross_tick), .peak_i(peak),
    .any_o(any_cross), .early_o(early_idx), .large_o(large_idx)
  );

  fr_score #(
    .NSEG(NSEG), .AMP_W(AMP_W), .SCORE_W(SCORE_W), .IDX_W(IDX_W),
    .RATIO_Q(RATIO_Q), .RATIO_PTS(RATIO_PTS),
    .LEAD_BONUS(LEAD_BONUS), .SIDE_BONUS(SIDE_BONUS)
  ) u_score (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .en_i(accept), .amp_i(amp),
    .bonus_en_i(bonus_en), .any_i(any_cross), .early_i(early_idx),
    .large_i(large_idx), .score_o(score)
  );

  fr_select #(.NSEG(NSEG), .SCORE_W(SCORE_W), .TICK_W(TICK_W), .IDX_W(IDX_W)) u_select (
    .clk(clk), .rst_n(rst_n), .score_i(score), .cross_tick_i(cross_tick),
    .best_idx_o(best_idx), .best_score_o(best_score)
  );

  // R2: the result strobe lasts one cycle
  a_r2_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R2: a result only follows the ranking step
  a_r2_after_rank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(state_q) == ST_RANK));

  // R2: the tick counter never reaches the window length inside a scan
  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> (tick_q < TICK_W'(WIN_TICKS)));

  // R1: an alarm in idle opens a fresh scan at tick zero
  a_r1_scan_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && alarm_i) |=> (state_q == ST_SCAN && tick_q == '0));
endmodule

// File: tb/fault_rank_engine_bench.sv
module fault_rank_engine_bench;
  localparam int NSEG = 4;
  localparam int AW   = 12;
  localparam int WIN  = 40;
  localparam int SMAX = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_i = 1'b0;
  logic [15:0] now_ts_i = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [NSEG-1:0] s_flag = '0;
  logic [NSEG*AW-1:0] s_amp = '0;
  logic res_valid;
  logic [1:0] res_seg;
  logic [5:0] res_score;
  logic [15:0] res_t_start, res_t_end;

  int n_chk = 0;
  int n_fail = 0;
  int ts = 0;
  int cyc = 0;
  bit f [WIN][NSEG];
  int a [WIN][NSEG];

  always #4 clk = ~clk;

  fault_rank_engine u_fault_rank_engine (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .now_ts_i(now_ts_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_flag(s_flag), .s_amp(s_amp),
    .res_valid(res_valid), .res_seg(res_seg), .res_score(res_score),
    .res_t_start(res_t_start), .res_t_end(res_t_end)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ts = ts + 1;
    now_ts_i = 16'(ts);
  endtask

  task automatic clear_pat();
    for (int t = 0; t < WIN; t++)
      for (int i = 0; i < NSEG; i++) begin
        f[t][i] = 1'b0;
        a[t][i] = 0;
      end
  endtask

  function automatic int sat(int v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  task automatic model(output int eseg, output int escore);
    int sc[NSEG]; int ct[NSEG]; int pk[NSEG]; bit cr[NSEG];
    int early; int big; int best; int ctb; int cti;
    for (int i = 0; i < NSEG; i++) begin sc[i] = 0; ct[i] = 0; pk[i] = 0; cr[i] = 0; end
    for (int t = 0; t < WIN; t++) begin
      for (int i = 0; i < NSEG; i++)
        if (f[t][i]) begin
          if (!cr[i]) begin cr[i] = 1; ct[i] = t; end
          if (a[t][i] > pk[i]) pk[i] = a[t][i];
        end
      for (int i = 1; i < NSEG; i++)
        if (a[t][i] * 4 > a[t][0] * 8) sc[i] = sat(sc[i] + 2);
    end
    early = -1; big = -1;
    for (int i = 0; i < NSEG; i++)
      if (cr[i]) begin
        if (early < 0 || ct[i] < ct[early]) early = i;
        if (big < 0 || pk[i] > pk[big]) big = i;
      end
    if (early >= 0) begin
      if (early == big) sc[early] = sat(sc[early] + 16);
      else begin
        sc[early] = sat(sc[early] + 4);
        sc[big]   = sat(sc[big] + 4);
      end
    end
    best = 0; ctb = cr[0] ? ct[0] : 1000;
    for (int i = 1; i < NSEG; i++) begin
      cti = cr[i] ? ct[i] : 1000;
      if (sc[i] > sc[best] || (sc[i] == sc[best] && cti < ctb)) begin
        best = i; ctb = cti;
      end
    end
    eseg = best; escore = sc[best];
  endtask

  task automatic run_scan(string tag, bit gaps);
    int es; int esc; int t_start; int t_end;
    model(es, esc);
    step();
    alarm_i = 1'b1; t_start = ts;
    step();
    alarm_i = 1'b0;
    for (int t = 0; t < WIN; t++) begin
      if (gaps && ($urandom % 4) == 0) begin
        s_valid = 1'b0;
        step();
      end
      s_valid = 1'b1;
      for (int i = 0; i < NSEG; i++) begin
        s_flag[i] = f[t][i];
        s_amp[i*AW +: AW] = AW'(a[t][i]);
      end
      t_end = ts;
      step();
    end
    s_valid = 1'b0;
    chk({"R8 ready low in close ", tag}, int'(s_ready), 0);
    chk({"R2 no early result ", tag}, int'(res_valid), 0);
    step();
    chk({"R8 ready low in rank ", tag}, int'(s_ready), 0);
    step();
    chk({"R2 result strobe ", tag}, int'(res_valid), 1);
    chk({"R7 segment ", tag}, int'(res_seg), es);
    chk({"R5 score ", tag}, int'(res_score), esc);
    chk({"R1 start ts ", tag}, int'(res_t_start), t_start & 16'hffff);
    chk({"R2 end ts ", tag}, int'(res_t_end), t_end & 16'hffff);
    step();
    chk({"R2 strobe one cycle ", tag}, int'(res_valid), 0);
    chk({"R8 ready back ", tag}, int'(s_ready), 1);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 res_valid", int'(res_valid), 0);
    chk("R9 s_ready", int'(s_ready), 1);
    chk("R9 res_seg", int'(res_seg), 0);
    chk("R9 res_score", int'(res_score), 0);
    chk("R9 res_t_end", int'(res_t_end), 0);
    rst_n = 1'b1;
    step();

    // R1: idle traffic with heavy ratio violations must leave no trace
    for (int k = 0; k < 6; k++) begin
      s_valid = 1'b1; s_flag = '1;
      s_amp = {12'd4095, 12'd4095, 12'd4095, 12'd0};
      step();
    end
    s_valid = 1'b0; s_flag = '0; s_amp = '0;
    clear_pat();
    run_scan("R1 idle ignored", 1'b0);

    // R5 full bonus: segment 2 first and largest
    clear_pat();
    for (int t = 0; t < WIN; t++) a[t][0] = 1000;
    for (int t = 5; t < WIN; t++) begin f[t][2] = 1; a[t][2] = 900; end
    for (int t = 8; t < WIN; t++) begin f[t][1] = 1; a[t][1] = 500; end
    run_scan("R5 lead bonus", 1'b0);

    // R7 crossing-time tiebreak: seg1 earlier, seg3 larger, equal scores
    clear_pat();
    for (int t = 0; t < WIN; t++) a[t][0] = 1000;
    f[3][1] = 1; a[3][1] = 300;
    f[6][3] = 1; a[6][3] = 1500;
    run_scan("R7 tick tiebreak", 1'b0);

    // R4 simultaneous first crossing goes to lower index
    clear_pat();
    for (int t = 0; t < WIN; t++) a[t][0] = 2000;
    f[0][3] = 1; a[0][3] = 1800;
    f[0][1] = 1; a[0][1] = 200;
    run_scan("R4 simultaneous", 1'b0);

    // R7 index tiebreak with ratio-only scores
    clear_pat();
    a[10][1] = 100; a[20][2] = 100;
    run_scan("R7 index tiebreak", 1'b0);

    // R3 ratio boundary: equal gives nothing, one above gives credit
    clear_pat();
    for (int t = 0; t < WIN; t++) begin a[t][0] = 500; a[t][3] = 1000; end
    a[0][3] = 1001;
    run_scan("R3 ratio boundary", 1'b0);

    // R6 saturation and clear at next scan
    clear_pat();
    for (int t = 0; t < WIN; t++) a[t][3] = 4095;
    f[0][3] = 1;
    run_scan("R6 saturate", 1'b1);
    clear_pat();
    run_scan("R6 cleared", 1'b0);

    // random scans with stream gaps
    for (int r = 0; r < 6; r++) begin
      clear_pat();
      for (int t = 0; t < WIN; t++)
        for (int i = 0; i < NSEG; i++) begin
          f[t][i] = (($urandom % 16) == 0);
          a[t][i] = (i == 0) ? int'($urandom % 1024) : int'($urandom % 4096);
        end
      run_scan("R3 R5 R7 random", 1'b1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule